// File: doc/BRIEF.md
# Timing Generator Operating-Mode Controller

This block is the mode sequencer for a timing generator that follows an input reference. It holds one of five operating modes: Free-run, Pre-Locked, Locked, Holdover and Pre-Locked2. It moves between them based on reference availability, loop lock indication, whether stable frequency history has been gathered, revertive reference restoration, a one-second tick and two software override requests. In Holdover the generator runs on stored frequency history and is not phase-locked to any input. A separate state, Pre-Locked2, handles re-acquisition after Holdover. It falls back to Holdover rather than Free-run, so the stored frequency is kept if the re-acquisition attempt fails.

The named transitions are as follows. Free-run goes to Pre-Locked on acquire-start. Pre-Locked goes to Locked on lock-found, to Free-run on ref-lost, and to Free-run on acquire-timeout. Locked goes to Holdover on ref-lost-with-history, to Free-run on ref-lost-without-history, to Holdover on software-hold, and to Pre-Locked2 (or to Pre-Locked without history) on revertive-switch. Holdover goes to Free-run on software-release and to Pre-Locked2 on reacquire. Pre-Locked2 goes to Locked on lock-found, and to Holdover on ref-lost, software-hold or reacquire-timeout. Acquisition attempts are bounded by counting one-second ticks. The block is used beside the loop filter and the reference qualifier, and it tells them which mode is in force.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the mode becomes Free-run and `hold_strobe` is low.
- R2: From Free-run, the mode becomes Pre-Locked one edge after `ref_valid` and `ref_selected` are both high; otherwise it stays Free-run.
- R3: In Pre-Locked, loss of `ref_valid` returns to Free-run (this takes priority). Otherwise `lock_det` moves to Locked.
- R4: In Pre-Locked, if 100 one-second ticks arrive without `lock_det`, the edge of the 100th tick moves to Free-run. After 99 ticks the mode is still Pre-Locked.
- R5: In Locked, loss of `ref_valid` moves to Holdover when `freq_stable` is high, and to Free-run when it is low.
- R6: In Holdover, either `ref_valid` with `ref_selected`, or `revertive_en` with `hi_pri_restored`, moves to Pre-Locked2. A restored flag without `revertive_en` is ignored.
- R7: In Locked with the reference still valid, `revertive_en` with `hi_pri_restored` moves to Pre-Locked2 when `freq_stable` is high, and to Pre-Locked when it is low. Without `revertive_en` the mode stays Locked.
- R8: In Pre-Locked2, `lock_det` moves to Locked and loss of `ref_valid` moves to Holdover. If the 100th tick arrives without lock, the mode moves to Holdover. A `lock_det` on the edge of the 100th tick wins and gives Locked. Cycles without a tick do not advance the count.
- R9: `sw_hold_req` forces Holdover from Pre-Locked2, and from Locked when `freq_stable` is high. It is ignored in Locked when `freq_stable` is low. `sw_release_req` forces Holdover to Free-run and takes priority over reacquire.
- R10: `hold_strobe` is high for exactly the first cycle in which `mode_state` shows Holdover, and is low at all other times.
- R11: `mode_state` encodes Free-run=0, Pre-Locked=1, Locked=2, Holdover=3, Pre-Locked2=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to Free-run |
| ref_valid | input | 1 | Currently selected reference is available |
| ref_selected | input | 1 | A reference has been selected and applied to the loop |
| hi_pri_restored | input | 1 | A higher-priority reference has come back |
| revertive_en | input | 1 | Revertive switching enabled |
| lock_det | input | 1 | Loop reports phase lock |
| freq_stable | input | 1 | Stable frequency history has been gathered in Locked |
| sec_tick | input | 1 | One-cycle pulse once per second |
| sw_hold_req | input | 1 | Software request to enter Holdover |
| sw_release_req | input | 1 | Software request to leave Holdover for Free-run |
| mode_state | output | 3 | Current mode (encoding in R11) |
| hold_strobe | output | 1 | One-cycle pulse on entry to Holdover |

## Verification
The hardest condition to reach is the tie between lock and expiry in Pre-Locked2. Getting there needs a full Locked phase with history, a reference drop into Holdover, a reacquire, and then exactly 99 ticks spread among idle cycles, with `lock_det` raised only on the 100th. The bench builds this path step by step and repeats the window with and without lock. Each Locked and Holdover decision is swept over all 32 combinations of its five inputs, and the expected mode is derived from the priority order.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
    typedef enum logic [2:0] {
        MODE_FREE = 3'd0,
        MODE_PRE  = 3'd1,
        MODE_LOCK = 3'd2,
        MODE_HOLD = 3'd3,
        MODE_PRE2 = 3'd4
    } sync_mode_e;
endpackage

// File: rtl/acq_window_timer.sv
module acq_window_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // counter is cleared whenever no acquisition attempt is running
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick && (cnt == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/mode_next_state.sv
module mode_next_state
    import sync_mode_pkg::*;
(
    input  sync_mode_e cur,
    input  logic       ref_valid,
    input  logic       ref_selected,
    input  logic       hi_pri_restored,
    input  logic       revertive_en,
    input  logic       lock_det,
    input  logic       freq_stable,
    input  logic       expire,
    input  logic       sw_hold_req,
    input  logic       sw_release_req,
    output sync_mode_e nxt
);
    logic acquire, revert;

    assign acquire = ref_valid && ref_selected;
    assign revert  = revertive_en && hi_pri_restored;

    always_comb begin
        nxt = cur;
        unique case (cur)
            MODE_FREE: begin
                if (acquire) nxt = MODE_PRE;
            end
            MODE_PRE: begin
                if (!ref_valid)    nxt = MODE_FREE;
                else if (lock_det) nxt = MODE_LOCK;
                else if (expire)   nxt = MODE_FREE;
            end
            MODE_LOCK: begin
                if (!ref_valid)                      nxt = freq_stable ? MODE_HOLD : MODE_FREE;
                else if (sw_hold_req && freq_stable) nxt = MODE_HOLD;
                else if (revert)                     nxt = freq_stable ? MODE_PRE2 : MODE_PRE;
            end
            MODE_HOLD: begin
                if (sw_release_req)         nxt = MODE_FREE;
                else if (acquire || revert) nxt = MODE_PRE2;
            end
            MODE_PRE2: begin
                if (sw_hold_req || !ref_valid) nxt = MODE_HOLD;
                else if (lock_det)             nxt = MODE_LOCK;
                else if (expire)               nxt = MODE_HOLD;
            end
            default: nxt = MODE_FREE;
        endcase
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int LOCK_TIMEOUT_S = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_valid,
    input  logic       ref_selected,
    input  logic       hi_pri_restored,
    input  logic       revertive_en,
    input  logic       lock_det,
    input  logic       freq_stable,
    input  logic       sec_tick,
    input  logic       sw_hold_req,
    input  logic       sw_release_req,
    output logic [2:0] mode_state,
    output logic       hold_strobe
);
    sync_mode_e cur, nxt;
    logic       acq_run, acq_expire;

    assign acq_run = (cur == MODE_PRE) || (cur == MODE_PRE2);

    acq_window_timer #(.LIMIT(LOCK_TIMEOUT_S)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (acq_run),
        .tick   (sec_tick),
        .expire (acq_expire)
    );

    mode_next_state u_next (
        .cur             (cur),
        .ref_valid       (ref_valid),
        .ref_selected    (ref_selected),
        .hi_pri_restored (hi_pri_restored),
        .revertive_en    (revertive_en),
        .lock_det        (lock_det),
        .freq_stable     (freq_stable),
        .expire          (acq_expire),
        .sw_hold_req     (sw_hold_req),
        .sw_release_req  (sw_release_req),
        .nxt             (nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur <= MODE_FREE;
        else     cur <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) hold_strobe <= 1'b0;
        else     hold_strobe <= (nxt == MODE_HOLD) && (cur != MODE_HOLD);
    end

    assign mode_state = cur;

    // R11
    legal_state_chk: assert property (@(posedge clk) disable iff (rst)
        mode_state <= 3'd4);

    // R10
    strobe_state_chk: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> mode_state == 3'd3);

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |=> !hold_strobe);

    // R5
    lock_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 3'd3 && $past(mode_state) == 3'd2) |-> $past(freq_stable));

    // R3
    pre_to_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 3'd2 && $past(mode_state) == 3'd1) |-> $past(lock_det));

    // R8
    pre2_to_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 3'd2 && $past(mode_state) == 3'd4) |-> $past(lock_det));
endmodule

// File: tb/sync_mode_ctrl_tb.sv
module sync_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_valid = 0, ref_selected = 0, hi_pri_restored = 0, revertive_en = 0;
    logic       lock_det = 0, freq_stable = 0, sec_tick = 0, sw_hold_req = 0, sw_release_req = 0;
    logic [2:0] mode_state;
    logic       hold_strobe;
    int         checks = 0, errors = 0;
    bit         done = 0;

    localparam logic [2:0] FR = 3'd0, PL = 3'd1, LK = 3'd2, HO = 3'd3, P2 = 3'd4;

    always #4 clk = ~clk;

    sync_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_selected(ref_selected),
        .hi_pri_restored(hi_pri_restored), .revertive_en(revertive_en), .lock_det(lock_det),
        .freq_stable(freq_stable), .sec_tick(sec_tick), .sw_hold_req(sw_hold_req),
        .sw_release_req(sw_release_req), .mode_state(mode_state), .hold_strobe(hold_strobe)
    );

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [2:0] exp_m, input logic exp_s);
        checks++;
        if (mode_state !== exp_m || hold_strobe !== exp_s) begin
            errors++;
            $display("FAIL %s: mode=%0d strobe=%0b expected mode=%0d strobe=%0b",
                     req, mode_state, hold_strobe, exp_m, exp_s);
        end
    endtask

    task automatic clear_in();
        ref_valid = 0; ref_selected = 0; hi_pri_restored = 0; revertive_en = 0;
        lock_det = 0; freq_stable = 0; sec_tick = 0; sw_hold_req = 0; sw_release_req = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1; cyc(); cyc();
        chk("R1 R11 reset", FR, 0);
        rst = 0;
    endtask

    task automatic go_locked(input logic st);
        do_reset();
        ref_valid = 1; ref_selected = 1; cyc();
        chk("R2 acquire", PL, 0);
        lock_det = 1; cyc();
        chk("R3 lock", LK, 0);
        lock_det = 0; freq_stable = st;
    endtask

    task automatic go_hold();
        go_locked(1);
        ref_valid = 0; ref_selected = 0; cyc();
        chk("R5 R10 enter hold", HO, 1);
        cyc();
        chk("R10 strobe drops", HO, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] e;
        do_reset();
        // R2: valid alone is not enough
        ref_valid = 1; cyc();
        chk("R2 no select", FR, 0);
        // R3: ref loss in Pre-Locked
        ref_selected = 1; cyc();
        chk("R2 acquire", PL, 0);
        ref_valid = 0; lock_det = 1; cyc();
        chk("R3 ref lost pre", FR, 0);

        // R4: timeout in Pre-Locked
        do_reset();
        ref_valid = 1; ref_selected = 1; cyc();
        sec_tick = 1;
        for (int i = 0; i < 99; i++) cyc();
        chk("R4 99 ticks", PL, 0);
        cyc();
        chk("R4 timeout", FR, 0);
        sec_tick = 0;

        // Locked sweep: R5 R7 R9
        for (int v = 0; v < 32; v++) begin
            go_locked(v[1]);
            ref_valid = v[0]; sw_hold_req = v[2]; revertive_en = v[3]; hi_pri_restored = v[4];
            cyc();
            if (!v[0])             e = v[1] ? HO : FR;
            else if (v[2] && v[1]) e = HO;
            else if (v[3] && v[4]) e = v[1] ? P2 : PL;
            else                   e = LK;
            chk("R5/R7/R9 locked sweep", e, e == HO);
        end

        // Holdover sweep: R6 R9
        for (int v = 0; v < 32; v++) begin
            go_hold();
            sw_release_req = v[0]; ref_selected = v[1]; ref_valid = v[2];
            revertive_en = v[3]; hi_pri_restored = v[4];
            cyc();
            if (v[0])                              e = FR;
            else if ((v[1] && v[2]) || (v[3] && v[4])) e = P2;
            else                                   e = HO;
            chk("R6/R9 hold sweep", e, 0);
        end

        // R8: Pre-Locked2 timeout with sparse ticks, then tie with lock
        for (int mode = 0; mode < 2; mode++) begin
            go_hold();
            ref_valid = 1; ref_selected = 1; cyc();
            chk("R6 reacquire", P2, 0);
            for (int i = 0; i < 99; i++) begin
                sec_tick = 1; cyc();
                sec_tick = 0; cyc(); cyc();
            end
            chk("R8 99 sparse ticks", P2, 0);
            sec_tick = 1; lock_det = (mode == 1); cyc();
            sec_tick = 0; lock_det = 0;
            if (mode == 0) chk("R8 timeout to hold", HO, 1);
            else           chk("R8 lock wins tie", LK, 0);
        end

        // R8: lock and ref loss in Pre-Locked2
        go_hold();
        ref_valid = 1; ref_selected = 1; cyc();
        lock_det = 1; cyc();
        chk("R8 lock from pre2", LK, 0);
        go_hold();
        ref_valid = 1; ref_selected = 1; cyc();
        ref_valid = 0; cyc();
        chk("R8 ref lost pre2", HO, 1);
        // R9: software hold in Pre-Locked2
        go_hold();
        ref_valid = 1; ref_selected = 1; cyc();
        sw_hold_req = 1; lock_det = 1; cyc();
        chk("R9 sw hold pre2", HO, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule